// File: doc/BRIEF.md
# Multi-Channel Match Timer Bank

This block holds eight timer channels, numbered 4 to 11. Each channel has a 32-bit counter, a 32-bit match register and a match-control register. The counter advances by one on each single-cycle strobe from a tick source the channel selects. The strobes come from outside the block. A channel can also leave its own counter idle and compare its match register against a pair leader's counter. A match can clear the channel's own counter. Matching can be periodic, or one-shot, in which case a write to the channel's match register or counter re-arms it.

Matches set per-channel status bits. A status bit is set only when its enable bit is set. One combined interrupt stays high while any status bit is set. Reading the counter of channel 9 or 11 with its snapshot bit set also copies the counter of channel 8 or 10 into a shared snapshot register.

Software reaches the block through a simple synchronous register port. A write takes effect at the clock edge where the write strobe is high. Read data is combinational from the current state, and any snapshot side effect takes place at that same edge.

Top module: `tmr_bank`

## Requirements
- R1: After synchronous reset every counter, match register, control register, the enable and status registers and the snapshot register read zero, the interrupt is low, and every channel is stopped.
- R2: Control bits [2:0] pick the tick source: codes 1, 2, 3, 4, 5 select `tick_strobe[0]` to `tick_strobe[4]`. Codes 0, 6 and 7 stop the channel. A counting counter rises by exactly one in each cycle where its selected strobe is high.
- R3: Channels 4 to 7 store only control bits [7:0]; channels 8 to 11 store bits [9:0]. Other bits read back as zero. On channels 8 to 11, control bit 8 set stops the channel's own counter whatever bits [2:0] hold.
- R4: With control bit 7 clear, channels 5, 6 and 7 compare against channel 4's counter, channel 9 against channel 8's and channel 11 against channel 10's, and the follower's own counter holds. Channels 4, 8 and 10 always use their own counter.
- R5: A match happens in the cycle where the compared counter advances on a tick to a value equal to the channel's match register. Loading a counter by a write is never a match.
- R6: With control bit 3 set, the channel's own counter becomes zero at the edge where the channel fires, in place of its normal advance.
- R7: With control bit 6 set, the channel fires on every match. With it clear, the channel fires once and then stays silent until its match register or its own counter is written. A reset leaves the channel unarmed.
- R8: Enable register at 0x1C and status register at 0x14 both use bits [11:4], bit N for channel N. A firing channel sets its status bit only if its enable bit is set. Writing 1 to a status bit clears it, and a set in the same cycle wins over the clear.
- R9: The `irq` output is high exactly while at least one status bit is set.
- R10: A read of channel 9's or 11's counter while that channel's control bit 9 is set copies the counter of channel 8 or 10 into the snapshot register at 0x20. Any other read leaves the snapshot unchanged.
- R11: Channel N (4 to 11) has its counter at 0x40 + 4*(N-4), its match register at 0x80 + 4*(N-4) and its control register at 0xC0 + 4*(N-4). A counter write loads the written value. A read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the snapshot side effect) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| tick_strobe | input | 5 | Single-cycle tick strobes, one per selectable source |
| irq | output | 1 | Combined match interrupt |

## Verification
The bench goes after several corners. A follower channel compares against its leader, and a design that counted the follower's own counter, or compared against the wrong leader, would leave its status bit clear or change the follower's counter. A one-shot channel must stay silent until it is re-armed, and a design that forgot to drop the armed state would raise status again on the next match. Reset-on-match must clear the counter in the same edge as the match, not one tick later. The bench also checks that bit 8 on a wide channel blocks ticks and that controls on narrow channels are truncated, and that the snapshot copies the partner counter only on a qualified read. A long random phase mixes leader changes, status clears that collide with new matches, and reads, all compared against a bench model.

// File: rtl/tmrb_pkg.sv
package tmrb_pkg;

    localparam int NCH      = 8;                // channels 4..11
    localparam int FIRST_CH = 4;                // channel number of index 0
    localparam int NSRC     = 5;                // selectable tick strobes
    localparam int CTRL_W   = 10;
    localparam int IDX_W    = $clog2(NCH);
    localparam int RGN_LSB  = IDX_W + 2;        // address bits above the channel index

    localparam logic [7:0] CNT_BASE   = 8'h40;
    localparam logic [7:0] MATCH_BASE = 8'h80;
    localparam logic [7:0] CTRL_BASE  = 8'hC0;
    localparam logic [7:0] STAT_ADDR  = 8'h14;
    localparam logic [7:0] EN_ADDR    = 8'h1C;
    localparam logic [7:0] SNAP_ADDR  = 8'h20;

    typedef struct packed {
        logic       snap_en;       // 9: counter read captures partner count
        logic       no_int;        // 8: wide channels only, blocks ticks
        logic       own_cnt;       // 7: use own counter instead of leader
        logic       periodic;      // 6: match repeatedly
        logic [1:0] spare;         // 5:4 stored, no effect
        logic       clr_on_match;  // 3: counter to zero on firing
        logic [2:0] src;           // 2:0 tick source
    } ctrl_t;

    // index of the channel whose counter a follower compares against
    function automatic int leader_of(input int idx);
        if (idx < 4)      return 0;
        else if (idx < 6) return 4;
        else              return 6;
    endfunction

    // channels whose counter read may capture the partner count
    function automatic logic snap_reader(input logic [IDX_W-1:0] idx);
        return (idx == IDX_W'(5)) || (idx == IDX_W'(7));
    endfunction

    function automatic logic src_strobe(input logic [2:0] sel,
                                        input logic [NSRC-1:0] s);
        if (sel >= 3'd1 && sel <= 3'(NSRC))
            return s[sel - 3'd1];
        return 1'b0;
    endfunction

endpackage

// File: rtl/tmrb_chan.sv
module tmrb_chan
    import tmrb_pkg::*;
#(
    parameter int IDX = 0,
    parameter int DW  = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] strobes,
    input  logic            wr_cnt,
    input  logic            wr_match,
    input  logic            wr_ctrl,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   lead_cnt,
    input  logic            lead_adv,
    output logic [DW-1:0]   cnt_q,
    output logic [DW-1:0]   match_q,
    output ctrl_t           ctrl_q,
    output logic            adv,
    output logic            fire
);

    localparam bit LEADER = (leader_of(IDX) == IDX);
    localparam bit WIDE   = (IDX >= NCH / 2);
    localparam logic [CTRL_W-1:0] KEEP =
        WIDE ? {CTRL_W{1'b1}} : {{(CTRL_W-8){1'b0}}, 8'hFF};

    logic          armed_q;
    logic          tick_on;
    logic          follow;
    logic          cmp_adv;
    logic [DW-1:0] cmp_cnt;

    always_comb begin
        tick_on = src_strobe(ctrl_q.src, strobes) && !(WIDE && ctrl_q.no_int);
        follow  = !LEADER && !ctrl_q.own_cnt;
        adv     = !follow && tick_on;
        cmp_cnt = follow ? lead_cnt : cnt_q;
        cmp_adv = follow ? lead_adv : adv;
        fire    = cmp_adv && ((cmp_cnt + 1'b1) == match_q)
                  && (ctrl_q.periodic || armed_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            match_q <= '0;
            ctrl_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            if (wr_cnt)
                cnt_q <= wdata;
            else if (fire && ctrl_q.clr_on_match)
                cnt_q <= '0;
            else if (adv)
                cnt_q <= cnt_q + 1'b1;

            if (wr_match)
                match_q <= wdata;

            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0] & KEEP);

            if (wr_cnt || wr_match)
                armed_q <= 1'b1;
            else if (fire && !ctrl_q.periodic)
                armed_q <= 1'b0;
        end
    end

    p_cnt_load_r11: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> cnt_q == $past(wdata));

    p_stopped_src_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_cnt && !fire && (ctrl_q.src == 3'd0 || ctrl_q.src > 3'(NSRC)))
        |=> $stable(cnt_q));

    p_no_int_r3: assert property (@(posedge clk) disable iff (rst)
        (WIDE && ctrl_q.no_int && !wr_cnt && !fire) |=> $stable(cnt_q));

    p_follow_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!LEADER && !ctrl_q.own_cnt && !wr_cnt && !fire) |=> $stable(cnt_q));

    p_clear_on_fire_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && ctrl_q.clr_on_match && !wr_cnt) |=> cnt_q == '0);

    p_oneshot_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && !ctrl_q.periodic && !wr_cnt && !wr_match) |=> !armed_q);

endmodule

// File: rtl/tmrb_evt.sv
module tmrb_evt
    import tmrb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] fire,
    input  logic           wr_en_reg,
    input  logic           wr_stat,
    input  logic [NCH-1:0] wbits,
    output logic [NCH-1:0] en_q,
    output logic [NCH-1:0] stat_q,
    output logic           irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            stat_q <= '0;
        end else begin
            if (wr_en_reg)
                en_q <= wbits;
            for (int i = 0; i < NCH; i++) begin
                if (fire[i] && en_q[i])
                    stat_q[i] <= 1'b1;
                else if (wr_stat && wbits[i])
                    stat_q[i] <= 1'b0;
            end
        end
    end

    assign irq = |stat_q;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chk
            p_stat_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
                $rose(stat_q[g]) |-> $past(en_q[g]) && $past(fire[g]));
        end
    endgenerate

    p_irq_drop_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wr_stat));

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_stat) |=> irq);

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmrb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] tick_strobe,
    output logic            irq
);

    localparam int RGN_W = AW - RGN_LSB;
    localparam logic [RGN_W-1:0] CNT_RGN   = CNT_BASE[AW-1:RGN_LSB];
    localparam logic [RGN_W-1:0] MATCH_RGN = MATCH_BASE[AW-1:RGN_LSB];
    localparam logic [RGN_W-1:0] CTRL_RGN  = CTRL_BASE[AW-1:RGN_LSB];

    logic [RGN_W-1:0] rgn;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] partner;
    logic             aligned, sel_cnt, sel_match, sel_ctrl;

    logic [DW-1:0]  cnt_w   [NCH];
    logic [DW-1:0]  match_w [NCH];
    ctrl_t          ctrl_w  [NCH];
    logic [NCH-1:0] adv_w, fire_w, en_w, stat_w;
    logic [DW-1:0]  snap_q;

    always_comb begin
        rgn       = bus_addr[AW-1:RGN_LSB];
        idx       = bus_addr[RGN_LSB-1:2];
        partner   = idx - 1'b1;
        aligned   = (bus_addr[1:0] == 2'b00);
        sel_cnt   = aligned && (rgn == CNT_RGN);
        sel_match = aligned && (rgn == MATCH_RGN);
        sel_ctrl  = aligned && (rgn == CTRL_RGN);
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            localparam int LEAD = leader_of(g);
            logic [DW-1:0] l_cnt;
            logic          l_adv;
            if (LEAD == g) begin : g_own
                assign l_cnt = '0;
                assign l_adv = 1'b0;
            end else begin : g_fol
                assign l_cnt = cnt_w[LEAD];
                assign l_adv = adv_w[LEAD];
            end
            tmrb_chan #(.IDX(g), .DW(DW)) u_chan (
                .clk      (clk),
                .rst      (rst),
                .strobes  (tick_strobe),
                .wr_cnt   (bus_wr && sel_cnt   && idx == IDX_W'(g)),
                .wr_match (bus_wr && sel_match && idx == IDX_W'(g)),
                .wr_ctrl  (bus_wr && sel_ctrl  && idx == IDX_W'(g)),
                .wdata    (bus_wdata),
                .lead_cnt (l_cnt),
                .lead_adv (l_adv),
                .cnt_q    (cnt_w[g]),
                .match_q  (match_w[g]),
                .ctrl_q   (ctrl_w[g]),
                .adv      (adv_w[g]),
                .fire     (fire_w[g])
            );
        end
    endgenerate

    tmrb_evt u_evt (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire_w),
        .wr_en_reg (bus_wr && bus_addr == EN_ADDR),
        .wr_stat   (bus_wr && bus_addr == STAT_ADDR),
        .wbits     (bus_wdata[FIRST_CH +: NCH]),
        .en_q      (en_w),
        .stat_q    (stat_w),
        .irq       (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (bus_rd && sel_cnt && snap_reader(idx) && ctrl_w[idx].snap_en)
            snap_q <= cnt_w[partner];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STAT_ADDR)
            bus_rdata[FIRST_CH +: NCH] = stat_w;
        else if (bus_addr == EN_ADDR)
            bus_rdata[FIRST_CH +: NCH] = en_w;
        else if (bus_addr == SNAP_ADDR)
            bus_rdata = snap_q;
        else if (sel_cnt)
            bus_rdata = cnt_w[idx];
        else if (sel_match)
            bus_rdata = match_w[idx];
        else if (sel_ctrl)
            bus_rdata[CTRL_W-1:0] = ctrl_w[idx];
    end

    p_snap_on_read_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(snap_q) |-> $past(bus_rd) && $past(sel_cnt));

endmodule

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [4:0]  tick_strobe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    tmr_bank uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_strobe(tick_strobe), .irq(irq)
    );

    // bench model of the register state, written from the requirements
    logic [31:0] m_cnt [8];
    logic [31:0] m_mat [8];
    logic [9:0]  m_ctl [8];
    logic        m_arm [8];
    logic [7:0]  m_en, m_st;
    logic [31:0] m_snap;

    function automatic int lead_idx(input int i);
        return (i < 4) ? 0 : ((i < 6) ? 4 : 6);
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        for (int i = 0; i < 8; i++) begin
            if (a == 8'h40 + 8'(4*i)) return m_cnt[i];
            if (a == 8'h80 + 8'(4*i)) return m_mat[i];
            if (a == 8'hC0 + 8'(4*i)) return {22'd0, m_ctl[i]};
        end
        if (a == 8'h14) return {20'd0, m_st, 4'd0};
        if (a == 8'h1C) return {20'd0, m_en, 4'd0};
        if (a == 8'h20) return m_snap;
        return 32'd0;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 8; i++) begin
            m_cnt[i] = 0; m_mat[i] = 0; m_ctl[i] = 0; m_arm[i] = 0;
        end
        m_en = 0; m_st = 0; m_snap = 0;
    endtask

    task automatic m_step(input logic wr, input logic rd, input logic [7:0] a,
                          input logic [31:0] d, input logic [4:0] tk);
        logic [7:0] adv, fire;
        for (int i = 0; i < 8; i++) begin
            logic [2:0] s = m_ctl[i][2:0];
            logic t = (s >= 1 && s <= 5) ? tk[s-1] : 1'b0;
            if (i >= 4 && m_ctl[i][8]) t = 1'b0;
            adv[i] = ((lead_idx(i) == i) || m_ctl[i][7]) && t;
        end
        for (int i = 0; i < 8; i++) begin
            bit fol = (lead_idx(i) != i) && !m_ctl[i][7];
            logic ca = fol ? adv[lead_idx(i)] : adv[i];
            logic [31:0] cc = fol ? m_cnt[lead_idx(i)] : m_cnt[i];
            fire[i] = ca && (cc + 1 == m_mat[i]) && (m_ctl[i][6] || m_arm[i]);
        end
        if (rd && (a == 8'h54) && m_ctl[5][9]) m_snap = m_cnt[4];
        if (rd && (a == 8'h5C) && m_ctl[7][9]) m_snap = m_cnt[6];
        for (int i = 0; i < 8; i++) begin
            bit wc = wr && a == 8'h40 + 8'(4*i);
            bit wm = wr && a == 8'h80 + 8'(4*i);
            if (fire[i] && m_en[i]) m_st[i] = 1'b1;
            else if (wr && a == 8'h14 && d[4+i]) m_st[i] = 1'b0;
            if (wc || wm) m_arm[i] = 1'b1;
            else if (fire[i] && !m_ctl[i][6]) m_arm[i] = 1'b0;
            if (wc) m_cnt[i] = d;
            else if (fire[i] && m_ctl[i][3]) m_cnt[i] = 0;
            else if (adv[i]) m_cnt[i] = m_cnt[i] + 1;
            if (wm) m_mat[i] = d;
            if (wr && a == 8'hC0 + 8'(4*i)) m_ctl[i] = d[9:0] & ((i < 4) ? 10'h0FF : 10'h3FF);
        end
        if (wr && a == 8'h1C) m_en = d[11:4];
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // one bus cycle; outputs are compared before the edge that commits it
    task automatic cyc(input logic wr, input logic rd, input logic [7:0] a,
                       input logic [31:0] d, input logic [4:0] tk, input string tag);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick_strobe = tk;
        #1;
        if (rd) chk(bus_rdata === m_read(a), tag, bus_rdata, m_read(a));
        chk(irq === (m_st != 0), "R9 irq", {31'd0, irq}, {31'd0, (m_st != 0)});
        m_step(wr, rd, a, d, tk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d, 5'd0, "wr");
    endtask

    task automatic tick(input logic [4:0] tk, input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 8'h00, 32'd0, tk, "tick");
    endtask

    // read compared with both the model and a literal value
    task automatic rdl(input logic [7:0] a, input logic [31:0] lit, input string tag);
        cyc(1'b0, 1'b1, a, 32'd0, 5'd0, tag);
        chk(bus_rdata === lit, tag, bus_rdata, lit);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; tick_strobe = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rdl(8'h40, 0, "R1 cnt4");
        rdl(8'hC0, 0, "R1 ctrl4");
        rdl(8'h9C, 0, "R1 match11");
        rdl(8'h20, 0, "R1 snap");
        rdl(8'h14, 0, "R1 status");
        chk(irq === 1'b0, "R1 irq", {31'd0, irq}, 0);

        // R11: counter load, unmapped read
        wr(8'h44, 32'h12345678);
        rdl(8'h44, 32'h12345678, "R11 cnt5 load");
        rdl(8'h04, 0, "R11 unmapped");

        // R2: source selection
        wr(8'hC0, 32'h1);
        tick(5'b00001, 3);
        tick(5'b00010, 2);
        rdl(8'h40, 3, "R2 src1");
        wr(8'hC0, 32'h5);
        tick(5'b10000, 2);
        tick(5'b01111, 1);
        rdl(8'h40, 5, "R2 src5");
        wr(8'hC0, 32'h6);
        tick(5'b11111, 2);
        rdl(8'h40, 5, "R2 src6 stopped");

        // R3: control width and tick block
        wr(8'hC4, 32'h3FF);
        rdl(8'hC4, 32'hFF, "R3 narrow ctrl");
        wr(8'hD0, 32'h3FF);
        rdl(8'hD0, 32'h3FF, "R3 wide ctrl");
        wr(8'hD0, 32'h101);
        wr(8'h50, 32'h0);
        tick(5'b00001, 3);
        rdl(8'h50, 0, "R3 bit8 blocks");
        wr(8'hD0, 32'h001);
        tick(5'b00001, 2);
        rdl(8'h50, 2, "R3 bit8 clear");

        // R4 R5 R8 R9: follower fires on leader count
        wr(8'h1C, 32'h20);
        wr(8'hC4, 32'h0);
        wr(8'h84, 32'd8);
        wr(8'hC0, 32'h1);
        tick(5'b00001, 2);
        rdl(8'h14, 0, "R5 no early match");
        tick(5'b00001, 1);
        rdl(8'h14, 32'h20, "R5 R8 follower match");
        chk(irq === 1'b1, "R9 irq high", {31'd0, irq}, 1);
        rdl(8'h44, 32'h12345678, "R4 follower holds");
        wr(8'h14, 32'h20);
        rdl(8'h14, 0, "R8 w1c");
        chk(irq === 1'b0, "R9 irq low", {31'd0, irq}, 0);

        // R7: one-shot stays silent, periodic repeats
        wr(8'h40, 32'd7);
        tick(5'b00001, 1);
        rdl(8'h14, 0, "R7 one-shot spent");
        wr(8'hC4, 32'h40);
        wr(8'h40, 32'd7);
        tick(5'b00001, 1);
        rdl(8'h14, 32'h20, "R7 periodic");
        wr(8'h14, 32'hFF0);

        // R6: clear on match
        wr(8'h1C, 32'h10);
        wr(8'hC0, 32'h49);
        wr(8'h80, 32'd3);
        wr(8'h40, 32'd0);
        tick(5'b00001, 3);
        rdl(8'h40, 0, "R6 cleared");
        rdl(8'h14, 32'h10, "R6 status");
        tick(5'b00001, 2);
        rdl(8'h40, 2, "R6 recount");
        wr(8'h14, 32'h10);

        // R10: snapshot
        wr(8'h50, 32'h77);
        wr(8'hD4, 32'h280);
        rdl(8'h54, 0, "R10 ch9 own cnt");
        rdl(8'h20, 32'h77, "R10 snap ch8");
        wr(8'hD4, 32'h080);
        tick(5'b00001, 1);
        rdl(8'h54, 0, "R10 no capture read");
        rdl(8'h20, 32'h77, "R10 snap unchanged");
        wr(8'hD8, 32'h4);
        tick(5'b01000, 4);
        wr(8'hDC, 32'h200);
        rdl(8'h5C, 0, "R10 ch11 own cnt");
        rdl(8'h20, 32'h4, "R10 snap ch10");

        // random phase against the model
        for (int n = 0; n < 6000; n++) begin
            int op = $urandom % 10;
            int ch = $urandom % 8;
            logic [4:0] tk = ($urandom % 3 == 0) ? 5'($urandom) : 5'd0;
            logic [7:0] a;
            logic [31:0] d;
            case ($urandom % 6)
                0: begin a = 8'h40 + 8'(4*ch); d = $urandom % 10; end
                1: begin a = 8'h80 + 8'(4*ch); d = $urandom % 12; end
                2: begin a = 8'hC0 + 8'(4*ch); d = $urandom % 1024; end
                3: begin a = 8'h14; d = $urandom; end
                4: begin a = 8'h1C; d = $urandom; end
                default: begin a = 8'h20; d = 0; end
            endcase
            if (op < 2)      cyc(1'b1, 1'b0, a, d, tk, "R2 R4 R5 R6 R7 R8 random write");
            else if (op < 6) cyc(1'b0, 1'b1, a, 0, tk, "R4 R5 R6 R7 R8 R10 random read");
            else             cyc(1'b0, 1'b0, 8'h00, 0, tk, "R9 random idle");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule